// File: doc/BRIEF.md
# Neural multiply-accumulate processing element

This block is one cell of a fixed-latency neural-network array. It keeps its own slice of weights in a small local store. A self-advancing pointer walks that store, so the central controller never has to supply weight addresses. Every step, the cell multiplies a signed 8-bit neuron state by the signed 16-bit weight at the pointer. It adds the product into a 29-bit accumulator and moves the pointer on by one.

A 2-bit command from the controller selects one of four actions each cycle: hold, clear, step, or load a weight. When a neuron's input sequence ends, the partial sum is on the output port and a valid flag marks it. Summing across a row, the activation function and transfer between rows all sit outside this cell.

Top module: `nmac_pe`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `psum_out` is 0, `psum_valid` is 0 and the weight pointer is at entry 0.
- R2: Command 2'b01 (clear) zeroes the accumulator and returns the pointer to entry 0. It discards a product still in flight from a step in the previous cycle. After the edge, `psum_out` is 0 and `psum_valid` is 0.
- R3: Command 2'b11 (load) writes `weight_in` into the weight store at the pointer and advances the pointer by one.
- R4: Command 2'b10 (step) multiplies `state_in` by the stored weight at the pointer and advances the pointer by one. The product is registered at that edge and enters the accumulator at the following edge.
- R5: Both operands are signed two's complement. The 24-bit product is sign-extended to 29 bits. The accumulator wraps modulo 2^29.
- R6: The pointer is shared by load and step. After entry DEPTH-1 it wraps to entry 0.
- R7: `psum_valid` goes high at the edge that absorbs the last product of a run of steps, provided the command in that cycle is not step or clear. Any step or clear drops it.
- R8: Command 2'b00 (idle) changes nothing: `psum_out` and `psum_valid` hold once no product is in flight.
- R9: `psum_out` always presents the full accumulator value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command: 00 idle, 01 clear, 10 step, 11 load |
| state_in | input | 8 | Signed neuron state for a step |
| weight_in | input | 16 | Signed weight written by a load |
| psum_out | output | 29 | Accumulated partial sum |
| psum_valid | output | 1 | Partial sum of the finished sequence is ready |

## Verification
The bench builds the cell with DEPTH set to 8 instead of 32. With that depth, a ninth load overwrites entry 0 and a ninth step reuses entry 0, so pointer wrap-around is reachable in a few cycles. The small store also makes the accumulator wrap reachable: refilling all eight entries with the most negative weight and running 129 steps at the most negative state pushes the sum past 2^29. Tables of constant-operand vectors and random dot products check the signed arithmetic. Short directed sequences cover clearing during an in-flight product and a load right after a step.

// File: rtl/nmac_pkg.sv
package nmac_pkg;

    localparam int STATE_W = 8;
    localparam int WGT_W   = 16;
    localparam int PROD_W  = STATE_W + WGT_W;
    localparam int ACC_W   = 29;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_CLEAR = 2'b01,
        CMD_STEP  = 2'b10,
        CMD_LOAD  = 2'b11
    } cmd_e;

    typedef struct packed {
        logic clear;
        logic step;
        logic load;
        logic idle;
    } ctl_t;

    function automatic logic [ACC_W-1:0] widen_prod(input logic [PROD_W-1:0] p);
        return {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
    endfunction

endpackage

// File: rtl/pe_cmd_decode.sv
module pe_cmd_decode
    import nmac_pkg::*;
(
    input  logic [1:0] cmd,
    output ctl_t       ctl
);
    always_comb begin
        ctl = '0;
        case (cmd_e'(cmd))
            CMD_CLEAR: ctl.clear = 1'b1;
            CMD_STEP:  ctl.step  = 1'b1;
            CMD_LOAD:  ctl.load  = 1'b1;
            default:   ctl.idle  = 1'b1;
        endcase
    end
endmodule

// File: rtl/pe_addr_gen.sv
module pe_addr_gen #(
    parameter int DEPTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          advance,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            addr <= '0;
        end else if (advance) begin
            addr <= (addr == LAST) ? '0 : addr + 1'b1;
        end
    end
endmodule

// File: rtl/pe_weight_mem.sv
module pe_weight_mem
    import nmac_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WGT_W-1:0] wdata,
    output logic [WGT_W-1:0] rdata
);
    logic [WGT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/pe_mac_unit.sv
module pe_mac_unit
    import nmac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ctl_t               ctl,
    input  logic [STATE_W-1:0] state,
    input  logic [WGT_W-1:0]   weight,
    output logic [ACC_W-1:0]   acc,
    output logic               done
);
    logic [PROD_W-1:0] prod_q;
    logic              pend_q;
    logic [PROD_W-1:0] prod_d;

    assign prod_d = PROD_W'($signed(state) * $signed(weight));

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            prod_q <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= ctl.step;
            if (ctl.step) begin
                prod_q <= prod_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            acc <= '0;
        end else if (pend_q) begin
            acc <= acc + widen_prod(prod_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clear || ctl.step) begin
            done <= 1'b0;
        end else if (pend_q) begin
            done <= 1'b1;
        end else if (!ctl.idle) begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/nmac_pe.sv
module nmac_pe
    import nmac_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         cmd,
    input  logic [STATE_W-1:0] state_in,
    input  logic [WGT_W-1:0]   weight_in,
    output logic [ACC_W-1:0]   psum_out,
    output logic               psum_valid
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    ctl_t             ctl;
    logic [AW-1:0]    wptr;
    logic [WGT_W-1:0] wcur;

    pe_cmd_decode u_dec (
        .cmd (cmd),
        .ctl (ctl)
    );

    pe_addr_gen #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .restart (ctl.clear),
        .advance (ctl.step | ctl.load),
        .addr    (wptr)
    );

    pe_weight_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (ctl.load & ~rst),
        .addr  (wptr),
        .wdata (weight_in),
        .rdata (wcur)
    );

    pe_mac_unit u_mac (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .state  (state_in),
        .weight (wcur),
        .acc    (psum_out),
        .done   (psum_valid)
    );
endmodule

// File: rtl/nmac_pe_chk.sv
module nmac_pe_chk
    import nmac_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cmd,
    input logic [ACC_W-1:0] psum_out,
    input logic             psum_valid
);
    logic past_ok;

    always_ff @(posedge clk) begin
        past_ok <= !rst;
    end

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_CLEAR) |=> (psum_out == '0 && !psum_valid));

    assert_step_drops_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> !psum_valid);

    assert_valid_after_run_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(cmd) == CMD_STEP && cmd != CMD_STEP && cmd != CMD_CLEAR)
        |=> psum_valid);

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(cmd) != CMD_STEP && cmd == CMD_IDLE)
        |=> ($stable(psum_out) && $stable(psum_valid)));

    assert_no_unknown_R9: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({psum_out, psum_valid}));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (psum_out == '0 && !psum_valid));
endmodule

bind nmac_pe nmac_pe_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .psum_out   (psum_out),
    .psum_valid (psum_valid)
);

// File: tb/tb_nmac_pe.sv
`timescale 1ns/1ps
module tb_nmac_pe;
    import nmac_pkg::*;

    localparam int DEPTH = 8;
    localparam int NVEC  = 6;

    typedef struct packed {
        logic [7:0]  len;
        logic [7:0]  st;
        logic [15:0] wt;
        logic [31:0] expv;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{8'd8, 8'sd127,  16'sd32767,  32'sd33291272},
        '{8'd8, -8'sd128, -16'sd32768, 32'sd33554432},
        '{8'd3, -8'sd1,   16'sd5,      -32'sd15},
        '{8'd1, 8'sd0,    16'sd1234,   32'sd0},
        '{8'd5, 8'sd100,  -16'sd300,   -32'sd150000},
        '{8'd8, -8'sd128, 16'sd32767,  -32'sd33553408}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        cmd;
    logic [7:0]        state_in;
    logic [15:0]       weight_in;
    logic [ACC_W-1:0]  psum_out;
    logic              psum_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    nmac_pe #(.DEPTH(DEPTH)) dut (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .state_in   (state_in),
        .weight_in  (weight_in),
        .psum_out   (psum_out),
        .psum_valid (psum_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    task automatic chk_sum(input string req, input int exp);
        logic [ACC_W-1:0] e;
        e = exp[ACC_W-1:0];
        check(req, 32'(psum_out), 32'(e));
    endtask

    task automatic cyc(input logic [1:0] c, input logic [7:0] s, input logic [15:0] w);
        cmd = c; state_in = s; weight_in = w;
        @(negedge clk);
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int ref_sum;
        logic [15:0] wr [DEPTH+1];
        logic [7:0]  sr [DEPTH];
        rst = 1'b1; cmd = CMD_IDLE; state_in = '0; weight_in = '0;
        repeat (3) @(negedge clk);
        check("R1 reset psum", 32'(psum_out), 0);
        check("R1 reset valid", 32'(psum_valid), 0);
        rst = 1'b0;
        cyc(CMD_IDLE, 0, 0);
        check("R1 post-reset psum", 32'(psum_out), 0);

        // table of constant-operand vectors: R3 R4 R5 R7
        for (int v = 0; v < NVEC; v++) begin
            cyc(CMD_CLEAR, 0, 0);
            for (int i = 0; i < DEPTH; i++) cyc(CMD_LOAD, 0, VECS[v].wt);
            for (int k = 0; k < int'(VECS[v].len); k++) cyc(CMD_STEP, VECS[v].st, 0);
            check("R7 valid low right after step", 32'(psum_valid), 0);
            cyc(CMD_IDLE, 0, 0);
            chk_sum("R4 R5 vector sum", int'($signed(VECS[v].expv)));
            check("R7 valid after run", 32'(psum_valid), 1);
        end

        // idle hold: R8
        for (int i = 0; i < 5; i++) cyc(CMD_IDLE, 0, 0);
        chk_sum("R8 idle hold psum", -33553408);
        check("R8 idle hold valid", 32'(psum_valid), 1);

        // random dot products: R3 R4 R5 R9
        for (int t = 0; t < 4; t++) begin
            cyc(CMD_CLEAR, 0, 0);
            ref_sum = 0;
            for (int i = 0; i < DEPTH; i++) begin
                wr[i] = 16'($urandom);
                sr[i] = 8'($urandom);
                cyc(CMD_LOAD, 0, wr[i]);
            end
            for (int i = 0; i < DEPTH; i++) begin
                cyc(CMD_STEP, sr[i], 0);
                ref_sum += int'($signed(sr[i])) * int'($signed(wr[i]));
            end
            cyc(CMD_IDLE, 0, 0);
            chk_sum("R9 random dot product", ref_sum);
        end

        // pointer wrap on load and step: R6 R2
        cyc(CMD_CLEAR, 0, 0);
        for (int i = 0; i <= DEPTH; i++) begin
            wr[i] = 16'(i * 37 + 11);
            cyc(CMD_LOAD, 0, wr[i]);
        end
        cyc(CMD_CLEAR, 0, 0);
        cyc(CMD_STEP, 8'd1, 0);
        cyc(CMD_IDLE, 0, 0);
        chk_sum("R6 ninth load overwrote entry 0", int'(wr[DEPTH]));
        cyc(CMD_CLEAR, 0, 0);
        ref_sum = 2 * int'(wr[DEPTH]);
        for (int i = 1; i < DEPTH; i++) ref_sum += int'(wr[i]);
        for (int i = 0; i <= DEPTH; i++) cyc(CMD_STEP, 8'd1, 0);
        cyc(CMD_IDLE, 0, 0);
        chk_sum("R6 ninth step reused entry 0", ref_sum);

        // clear cancels in-flight product: R2
        cyc(CMD_STEP, 8'd5, 0);
        cyc(CMD_CLEAR, 0, 0);
        chk_sum("R2 clear zeroes sum", 0);
        check("R2 clear drops valid", 32'(psum_valid), 0);
        cyc(CMD_IDLE, 0, 0);
        chk_sum("R2 pending product discarded", 0);

        // load right after step: R3 R4 R7
        cyc(CMD_STEP, 8'd3, 0);
        cyc(CMD_LOAD, 0, 16'd999);
        chk_sum("R4 product absorbed during load", 3 * int'(wr[DEPTH]));
        check("R7 valid after step then load", 32'(psum_valid), 1);
        cyc(CMD_CLEAR, 0, 0);
        cyc(CMD_STEP, 8'd0, 0);
        cyc(CMD_STEP, 8'd1, 0);
        cyc(CMD_IDLE, 0, 0);
        chk_sum("R3 load wrote entry 1", 999);

        // accumulator wrap modulo 2^29: R5
        cyc(CMD_CLEAR, 0, 0);
        for (int i = 0; i < DEPTH; i++) cyc(CMD_LOAD, 0, 16'h8000);
        for (int i = 0; i < 129; i++) cyc(CMD_STEP, 8'h80, 0);
        cyc(CMD_IDLE, 0, 0);
        chk_sum("R5 accumulator wraps", 4194304);

        // reset mid-operation: R1
        rst = 1'b1;
        cyc(CMD_IDLE, 0, 0);
        check("R1 reset clears sum", 32'(psum_out), 0);
        check("R1 reset clears valid", 32'(psum_valid), 0);
        rst = 1'b0;

        report();
    end
endmodule